// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A 32-pin general-purpose I/O bank controlled over a simple word-addressed register bus (address, write enable, write data, combinational read data). Each pin has an output value and an output enable. Both change only through strobe addresses: a write-one-to-set address and a write-one-to-clear address. Pad inputs pass through a two-flop synchronizer and an optional per-pin debounce filter. The filtered values are readable.

Rising and falling transitions of the filtered inputs are caught in two separate pending registers, each gated by its own enable register. Writing ones to a pending register acknowledges those bits. A single interrupt line is high while any pending bit of either kind is set.

Pull control is a pair of per-pin registers: an enable and a direction. They are exported as decoded pull-up and pull-down outputs for the pad ring. Debounce uses one bank-wide divider field, which sets the rate of the ticks every filtered pin counts.

Top module: `gpio_bank`

Word addresses (byte offset = word × 4): 0 input value (read), 1 output value (read), 2 output set, 3 output clear, 6 output enable (read), 7 output-enable set, 8 output-enable clear, 9 debounce enable, 10 rising enable, 11 falling enable, 12 rising pending, 13 falling pending, 14 clock divider, 20 pull enable, 21 pull direction. Strobe and unmapped addresses read as 0.

## Requirements
- R1: After reset every register reads 0 and `pad_oe`, `pad_out` and `irq` are 0.
- R2: A write to word 7 sets the output-enable bits where the data has ones, and a write to word 8 clears them; zero bits leave the register unchanged. The value reads back at word 6 and drives `pad_oe`.
- R3: A write to word 2 sets and a write to word 3 clears output-value bits where the data has ones. The value reads back at word 1 and drives `pad_out`.
- R4: With debounce off, word 0 returns `pad_in` after a two-flop synchronizer and one filter register, three clock edges after the pad changes.
- R5: A 0-to-1 change of a filtered input sets its bit in rising pending (word 12) only if its bit in rising enable (word 10) is 1.
- R6: A 1-to-0 change of a filtered input sets its bit in falling pending (word 13) only if its bit in falling enable (word 11) is 1.
- R7: Writing ones to a pending word clears those bits; bits written with 0 keep their value. If an enabled edge and a clear of the same bit happen in the same cycle, the bit ends up set.
- R8: `irq` is 1 exactly when any bit of either pending register is 1.
- R9: Pull enable (word 20) and pull direction (word 21, 1 = up, 0 = down) read back. `pull_up` is enable AND direction, and `pull_down` is enable AND NOT direction.
- R10: For a pin whose debounce enable bit (word 9) is set, a new input level is accepted only after it has stayed stable for DB_TICKS divider ticks. A shorter pulse changes neither the input value nor the pending bits.
- R11: The divider is held in bits 29:16 of word 14, and a tick occurs every divider+1 clocks. The other bits of word 14 are not stored and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Output values |
| pad_oe | output | 32 | Output enables |
| pull_up | output | 32 | Pull-up request per pin |
| pull_down | output | 32 | Pull-down request per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench uses the default parameters: 32 pins, a 14-bit divider at bits 29:16, DB_TICKS of 4 and two synchronizer stages. Before testing debounce, it programs the divider to 3. That gives a rejection window of about 16 clocks, so a 5-cycle glitch and a 60-cycle hold are both cheap to produce. The full divider field width is still covered by an all-ones write and readback. Exact synchronizer latency is used to line up a pending-bit clear with a new edge in the same cycle.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS    = 32,
  parameter int AW       = 6,
  parameter int DIV_LSB  = 16,
  parameter int DIV_W    = 14,
  parameter int DB_TICKS = 4,
  parameter int SYNC     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pull_up,
  output logic [NPINS-1:0] pull_down,
  output logic             irq
);
  localparam logic [AW-1:0] A_IN = 0, A_OUT = 1, A_OSET = 2, A_OCLR = 3,
    A_OE = 6, A_OESET = 7, A_OECLR = 8, A_DBEN = 9, A_REN = 10, A_FEN = 11,
    A_RPEND = 12, A_FPEND = 13, A_DIV = 14, A_PEN = 20, A_PDIR = 21;
  localparam int CW = (DB_TICKS > 2) ? $clog2(DB_TICKS) : 1;
  localparam logic [CW-1:0] CLAST = CW'(DB_TICKS - 1);

  logic [NPINS-1:0] sync_q [SYNC];
  logic [NPINS-1:0] in_q, in_nxt, raw;
  logic [NPINS-1:0] out_q, oe_q, db_en, rise_en, fall_en;
  logic [NPINS-1:0] rise_pend, fall_pend, pull_en, pull_dir;
  logic [DIV_W-1:0] div_q, pre_q;
  logic             tick;

  wire wr = wr_en;
  wire [NPINS-1:0] wd = wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int k = 0; k < SYNC; k++) sync_q[k] <= '0;
    else begin
      sync_q[0] <= pad_in;
      for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
    end
  assign raw = sync_q[SYNC-1];

  assign tick = (pre_q >= div_q);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else pre_q <= tick ? '0 : pre_q + 1'b1;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [CW-1:0] dcnt;
    wire differ = raw[i] ^ in_q[i];
    assign in_nxt[i] = !db_en[i] ? raw[i] :
                       (differ && tick && dcnt == CLAST) ? raw[i] : in_q[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dcnt <= '0;
      else if (!db_en[i] || !differ) dcnt <= '0;
      else if (tick) dcnt <= (dcnt == CLAST) ? '0 : dcnt + 1'b1;
  end

  wire [NPINS-1:0] rise_ev = in_nxt & ~in_q & rise_en;
  wire [NPINS-1:0] fall_ev = ~in_nxt & in_q & fall_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_q <= '0; out_q <= '0; oe_q <= '0; db_en <= '0;
      rise_en <= '0; fall_en <= '0; rise_pend <= '0; fall_pend <= '0;
      pull_en <= '0; pull_dir <= '0; div_q <= '0;
    end else begin
      in_q <= in_nxt;
      rise_pend <= (rise_pend & ~((wr && addr == A_RPEND) ? wd : '0)) | rise_ev;
      fall_pend <= (fall_pend & ~((wr && addr == A_FPEND) ? wd : '0)) | fall_ev;
      if (wr)
        case (addr)
          A_OSET:  out_q   <= out_q | wd;
          A_OCLR:  out_q   <= out_q & ~wd;
          A_OESET: oe_q    <= oe_q | wd;
          A_OECLR: oe_q    <= oe_q & ~wd;
          A_DBEN:  db_en   <= wd;
          A_REN:   rise_en <= wd;
          A_FEN:   fall_en <= wd;
          A_DIV:   div_q   <= wdata[DIV_LSB +: DIV_W];
          A_PEN:   pull_en <= wd;
          A_PDIR:  pull_dir <= wd;
          default: ;
        endcase
    end

  always_comb begin
    rdata = '0;
    case (addr)
      A_IN:    rdata[NPINS-1:0] = in_q;
      A_OUT:   rdata[NPINS-1:0] = out_q;
      A_OE:    rdata[NPINS-1:0] = oe_q;
      A_DBEN:  rdata[NPINS-1:0] = db_en;
      A_REN:   rdata[NPINS-1:0] = rise_en;
      A_FEN:   rdata[NPINS-1:0] = fall_en;
      A_RPEND: rdata[NPINS-1:0] = rise_pend;
      A_FPEND: rdata[NPINS-1:0] = fall_pend;
      A_DIV:   rdata[DIV_LSB +: DIV_W] = div_q;
      A_PEN:   rdata[NPINS-1:0] = pull_en;
      A_PDIR:  rdata[NPINS-1:0] = pull_dir;
      default: ;
    endcase
  end

  assign pad_out   = out_q;
  assign pad_oe    = oe_q;
  assign pull_up   = pull_en & pull_dir;
  assign pull_down = pull_en & ~pull_dir;
  assign irq       = |{rise_pend, fall_pend};
endmodule

module gpio_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             wr_en,
  input logic [31:0]      wdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pull_up,
  input logic [NPINS-1:0] pull_down,
  input logic             irq,
  input logic [NPINS-1:0] rise_en,
  input logic [NPINS-1:0] fall_en
);
  p_oe_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(7)) |=> ((pad_oe & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));
  p_oe_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8)) |=> ((pad_oe & $past(wdata[NPINS-1:0])) == '0));
  p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> ((pad_out & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])));
  p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3)) |=> ((pad_out & $past(wdata[NPINS-1:0])) == '0));
  p_pull_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & pull_down) == '0);
  p_no_irq_when_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(irq) && $past(rise_en == '0 && fall_en == '0)) |-> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (.*);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  addr = '0;
  logic        wr_en = 0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe, pull_up, pull_down;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_bank u_gpio_bank (.clk, .rst_n, .addr, .wr_en, .wdata, .rdata, .pad_in,
    .pad_out, .pad_oe, .pull_up, .pull_down, .irq);

  // kind: 0 write, 1 read-compare, 2 drive pad and wait, 3 irq compare
  localparam int NV = 36;
  localparam logic [75:0] VEC [NV] = '{
    {2'd0, 4'd2, 6'd7,  32'h0000_00FF, 32'h0},          // R2
    {2'd1, 4'd2, 6'd6,  32'h0,         32'h0000_00FF},  // R2
    {2'd0, 4'd2, 6'd8,  32'h0000_000F, 32'h0},          // R2
    {2'd1, 4'd2, 6'd6,  32'h0,         32'h0000_00F0},  // R2
    {2'd0, 4'd2, 6'd8,  32'h0,         32'h0},          // R2 zeros
    {2'd1, 4'd2, 6'd6,  32'h0,         32'h0000_00F0},  // R2
    {2'd0, 4'd3, 6'd2,  32'hA5A5_0000, 32'h0},          // R3
    {2'd1, 4'd3, 6'd1,  32'h0,         32'hA5A5_0000},  // R3
    {2'd0, 4'd3, 6'd3,  32'h8000_0001, 32'h0},          // R3
    {2'd1, 4'd3, 6'd1,  32'h0,         32'h25A5_0000},  // R3
    {2'd0, 4'd5, 6'd10, 32'h0000_0003, 32'h0},          // R5
    {2'd0, 4'd6, 6'd11, 32'h0000_0006, 32'h0},          // R6
    {2'd2, 4'd4, 6'd0,  32'h0000_0005, 32'h0},          // R4
    {2'd1, 4'd4, 6'd0,  32'h0,         32'h0000_0005},  // R4
    {2'd1, 4'd5, 6'd12, 32'h0,         32'h0000_0001},  // R5
    {2'd1, 4'd6, 6'd13, 32'h0,         32'h0},          // R6
    {2'd3, 4'd8, 6'd0,  32'h0,         32'h1},          // R8
    {2'd2, 4'd4, 6'd0,  32'h0,         32'h0},          // R4
    {2'd1, 4'd6, 6'd13, 32'h0,         32'h0000_0004},  // R6
    {2'd1, 4'd5, 6'd12, 32'h0,         32'h0000_0001},  // R5
    {2'd0, 4'd7, 6'd12, 32'h0,         32'h0},          // R7
    {2'd1, 4'd7, 6'd12, 32'h0,         32'h0000_0001},  // R7 zeros
    {2'd0, 4'd7, 6'd12, 32'h0000_0001, 32'h0},          // R7
    {2'd1, 4'd7, 6'd12, 32'h0,         32'h0},          // R7
    {2'd3, 4'd8, 6'd0,  32'h0,         32'h1},          // R8
    {2'd0, 4'd7, 6'd13, 32'h0000_0004, 32'h0},          // R7
    {2'd3, 4'd8, 6'd0,  32'h0,         32'h0},          // R8
    {2'd2, 4'd5, 6'd0,  32'h0000_0008, 32'h0},          // R5
    {2'd1, 4'd5, 6'd12, 32'h0,         32'h0},          // R5 disabled pin
    {2'd3, 4'd8, 6'd0,  32'h0,         32'h0},          // R8
    {2'd0, 4'd9, 6'd20, 32'h0000_00F0, 32'h0},          // R9
    {2'd0, 4'd9, 6'd21, 32'h0000_0030, 32'h0},          // R9
    {2'd1, 4'd9, 6'd21, 32'h0,         32'h0000_0030},  // R9
    {2'd0, 4'd11,6'd14, 32'hFFFF_FFFF, 32'h0},          // R11
    {2'd1, 4'd11,6'd14, 32'h0,         32'h3FFF_0000},  // R11
    {2'd0, 4'd11,6'd14, 32'h0003_0000, 32'h0}           // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic drive(input logic [31:0] v, input int cyc);
    @(negedge clk); pad_in = v;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'd1, 32'h0, "R1"); rd(6'd6, 32'h0, "R1");
    rd(6'd10, 32'h0, "R1"); rd(6'd11, 32'h0, "R1");
    rd(6'd12, 32'h0, "R1"); rd(6'd13, 32'h0, "R1");
    check("R1", {pad_oe[30:0], irq}, 32'h0);
    check("R1", pad_out, 32'h0);

    for (int n = 0; n < NV; n++) begin
      logic [1:0]  k;
      logic [3:0]  r;
      logic [5:0]  a;
      logic [31:0] d, e;
      string tag;
      {k, r, a, d, e} = VEC[n];
      tag = $sformatf("R%0d", r);
      case (k)
        2'd0: wr(a, d);
        2'd1: rd(a, e, tag);
        2'd2: drive(d, 4);
        default: begin @(negedge clk); check(tag, {31'd0, irq}, e); end
      endcase
    end

    check("R2", pad_oe, 32'h0000_00F0);
    check("R3", pad_out, 32'h25A5_0000);
    check("R9", pull_up, 32'h0000_0030);
    check("R9", pull_down, 32'h0000_00C0);

    // R7: clear and new edge in the same cycle -> set wins (pad currently 0x8)
    wr(6'd10, 32'h0000_0020);
    drive(32'h0000_0028, 4);
    rd(6'd12, 32'h0000_0020, "R7");
    drive(32'h0000_0008, 4);
    @(negedge clk); pad_in = 32'h0000_0028;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 6'd12; wdata = 32'h0000_0020; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(6'd12, 32'h0000_0020, "R7");
    wr(6'd12, 32'h0000_0020);
    rd(6'd12, 32'h0000_0000, "R7");

    // R10 debounce on bit 6, divider 3 already set (R11)
    wr(6'd10, 32'h0000_0040);
    wr(6'd9, 32'h0000_0040);
    drive(32'h0000_0068, 5);
    drive(32'h0000_0028, 40);
    rd(6'd0, 32'h0000_0028, "R10");
    rd(6'd12, 32'h0000_0000, "R10");
    drive(32'h0000_0068, 60);
    rd(6'd0, 32'h0000_0068, "R10");
    rd(6'd12, 32'h0000_0040, "R10");
    check("R8", {31'd0, irq}, 32'h1);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule